// File: doc/BRIEF.md
# Coalescing Store Buffer

This block sits between a write-through cache and main memory. The processor hands it stores and carries on without waiting for memory. Each slot holds one block address, a data word for every position in that block, and a bit per word that marks which words hold data. When a store falls in a block that a slot already holds, the word is folded into that slot and no new slot is used. Memory then receives one write that covers several words.

Slots leave through a drain port with a valid/ready handshake, oldest first. A read looks into the buffer and returns buffered data when its word is held there. If the word is not held, the read is flagged for memory, and no new drain starts while that flag is raised, so the read goes ahead of pending writes. A store that matches no slot while every slot is taken is held off until a slot drains. The slot being drained is closed to merging.

Top module: `merge_wbuf`

## Requirements
- R1: After reset the buffer is empty. `drValid`, `full` and `stStall` are low.
- R2: A store to a block that no open slot holds takes a new slot. Its drain shows the block address (`stAddr` without its low word-offset bits) on `drAddr`. `drMask` bit i marks word offset i, and that word appears on `drData[i*DATA_W +: DATA_W]`.
- R3: A store to a block held by an open slot merges into that slot. It sets the word's mask bit and replaces the word's data, later stores winning, and it takes no new slot.
- R4: Slots drain in the order they were allocated. A merge does not move a slot in that order.
- R5: `full` is high when every slot is occupied. A store that matches no slot while full raises `stStall` in the same cycle and is not taken. A store that merges is taken even while full.
- R6: A store to the block of the slot on the drain port (`drValid` high) does not merge into it. It takes a new slot.
- R7: When `rdValid` is high and the word at `rdAddr` is held by a slot, `rdHit` is high in the same cycle and `rdData` gives the newest buffered value of that word.
- R8: When `rdValid` is high and the word is not held, `rdToMem` is high, and a drain that has not yet started does not start while this holds.
- R9: While `drValid` is high and `drReady` is low, `drAddr`, `drData` and `drMask` hold steady.
- R10: A slot is released only by an accepted drain (`drValid` and `drReady`). A stalled store is taken once a drain frees a slot, and `drValid` stays low when the buffer is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| stValid | input | 1 | Store request |
| stAddr | input | ADDR_W | Store word address |
| stData | input | DATA_W | Store data |
| stStall | output | 1 | Store not taken this cycle |
| full | output | 1 | All slots occupied |
| rdValid | input | 1 | Read lookup request |
| rdAddr | input | ADDR_W | Read word address |
| rdHit | output | 1 | Read word held in the buffer |
| rdData | output | DATA_W | Forwarded read data |
| rdToMem | output | 1 | Read must go to memory |
| drValid | output | 1 | Drain write offered |
| drReady | input | 1 | Memory accepts the drain |
| drAddr | output | ADDR_W-log2(WORDS) | Drain block address |
| drData | output | WORDS*DATA_W | Drain block data |
| drMask | output | WORDS | Drain word-valid mask |

## Verification
The merge logic is tested with three store patterns. The first interleaves two blocks and rewrites one word, which separates a true merge and overwrite from a fresh allocation and checks drain order. The second fills every slot and then offers one merging store and one new-block store: only the new-block store may stall, and it must be taken once the oldest slot drains. The third stores to the block currently on the drain port, which must yield a second drain rather than a change to the one in flight. Reads are made at a held word and at an absent word; these separate forwarding from the memory-first path.

// File: rtl/merge_wbuf_pkg.sv
package merge_wbuf_pkg;
  typedef struct packed {
    logic doAlloc;
    logic doMerge;
    logic doRetire;
    logic lockHead;
  } wbStrobes_t;
endpackage

// File: rtl/merge_wbuf_dp.sv
module merge_wbuf_dp
  import merge_wbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 4,
  localparam int OFF_W = $clog2(WORDS),
  localparam int TAG_W = ADDR_W - OFF_W,
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  wbStrobes_t              strobes,
  input  logic [PTR_W-1:0]        headPtr,
  input  logic [PTR_W-1:0]        tailPtr,
  input  logic [ADDR_W-1:0]       stAddr,
  input  logic [DATA_W-1:0]       stData,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic                    storeMatch,
  output logic                    rawHit,
  output logic [DATA_W-1:0]       rdData,
  output logic [TAG_W-1:0]        drAddr,
  output logic [WORDS*DATA_W-1:0] drData,
  output logic [WORDS-1:0]        drMask
);
  logic              slotValid [DEPTH];
  logic [TAG_W-1:0]  slotTag   [DEPTH];
  logic [WORDS-1:0]  slotMask  [DEPTH];
  logic [DATA_W-1:0] slotData  [DEPTH][WORDS];

  logic [OFF_W-1:0] stOff, rdOff;
  logic [TAG_W-1:0] stTag, rdTag;
  logic [PTR_W-1:0] matchIdx;

  assign stOff = stAddr[OFF_W-1:0];
  assign stTag = stAddr[ADDR_W-1:OFF_W];
  assign rdOff = rdAddr[OFF_W-1:0];
  assign rdTag = rdAddr[ADDR_W-1:OFF_W];

  // Store compare against every open slot; the slot on the drain port is closed.
  always_comb begin
    storeMatch = 1'b0;
    matchIdx   = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (slotValid[i] && slotTag[i] == stTag &&
          !(strobes.lockHead && PTR_W'(i) == headPtr)) begin
        storeMatch = 1'b1;
        matchIdx   = PTR_W'(i);
      end
    end
  end

  // Read lookup walks slots oldest to newest so the newest copy wins.
  always_comb begin
    logic [PTR_W-1:0] idx;
    rawHit = 1'b0;
    rdData = '0;
    for (int k = 0; k < DEPTH; k++) begin
      idx = headPtr + PTR_W'(k);
      if (slotValid[idx] && slotTag[idx] == rdTag && slotMask[idx][rdOff]) begin
        rawHit = 1'b1;
        rdData = slotData[idx][rdOff];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < DEPTH; i++) begin
        slotValid[i] <= 1'b0;
        slotTag[i]   <= '0;
        slotMask[i]  <= '0;
        for (int w = 0; w < WORDS; w++) slotData[i][w] <= '0;
      end
    end else begin
      if (strobes.doRetire) begin
        slotValid[headPtr] <= 1'b0;
        slotMask[headPtr]  <= '0;
      end
      if (strobes.doAlloc) begin
        slotValid[tailPtr] <= 1'b1;
        slotTag[tailPtr]   <= stTag;
        slotMask[tailPtr]  <= WORDS'(1) << stOff;
        for (int w = 0; w < WORDS; w++)
          slotData[tailPtr][w] <= (OFF_W'(w) == stOff) ? stData : '0;
      end
      if (strobes.doMerge) begin
        slotMask[matchIdx][stOff] <= 1'b1;
        slotData[matchIdx][stOff] <= stData;
      end
    end
  end

  assign drAddr = slotTag[headPtr];
  assign drMask = slotMask[headPtr];
  for (genvar w = 0; w < WORDS; w++) begin : g_drWord
    assign drData[w*DATA_W +: DATA_W] = slotData[headPtr][w];
  end
endmodule

// File: rtl/merge_wbuf_ctrl.sv
module merge_wbuf_ctrl
  import merge_wbuf_pkg::*;
#(
  parameter int DEPTH = 4,
  localparam int PTR_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             stValid,
  input  logic             storeMatch,
  input  logic             rdMiss,
  input  logic             drReady,
  output wbStrobes_t       strobes,
  output logic [PTR_W-1:0] headPtr,
  output logic [PTR_W-1:0] tailPtr,
  output logic             full,
  output logic             stStall,
  output logic             drValid
);
  logic [CNT_W-1:0] count;
  logic             drBusy;

  assign full    = (count == CNT_W'(DEPTH));
  assign stStall = stValid && !storeMatch && full;
  assign drValid = drBusy;

  assign strobes.doMerge  = stValid && storeMatch;
  assign strobes.doAlloc  = stValid && !storeMatch && !full;
  assign strobes.doRetire = drBusy && drReady;
  assign strobes.lockHead = drBusy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      count   <= '0;
      headPtr <= '0;
      tailPtr <= '0;
      drBusy  <= 1'b0;
    end else begin
      count <= count + CNT_W'(strobes.doAlloc) - CNT_W'(strobes.doRetire);
      if (strobes.doAlloc)  tailPtr <= tailPtr + 1'b1;
      if (strobes.doRetire) headPtr <= headPtr + 1'b1;
      if (strobes.doRetire)                                drBusy <= 1'b0;
      else if (!drBusy && count != '0 && !rdMiss)          drBusy <= 1'b1;
    end
  end
endmodule

// File: rtl/merge_wbuf.sv
module merge_wbuf
  import merge_wbuf_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4,
  parameter int DEPTH  = 4,
  localparam int TAG_W = ADDR_W - $clog2(WORDS),
  localparam int PTR_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    stValid,
  input  logic [ADDR_W-1:0]       stAddr,
  input  logic [DATA_W-1:0]       stData,
  output logic                    stStall,
  output logic                    full,
  input  logic                    rdValid,
  input  logic [ADDR_W-1:0]       rdAddr,
  output logic                    rdHit,
  output logic [DATA_W-1:0]       rdData,
  output logic                    rdToMem,
  output logic                    drValid,
  input  logic                    drReady,
  output logic [TAG_W-1:0]        drAddr,
  output logic [WORDS*DATA_W-1:0] drData,
  output logic [WORDS-1:0]        drMask
);
  wbStrobes_t       strobes;
  logic [PTR_W-1:0] headPtr, tailPtr;
  logic             storeMatch, rawHit;

  assign rdHit   = rdValid && rawHit;
  assign rdToMem = rdValid && !rawHit;

  merge_wbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rstN(rstN), .stValid(stValid), .storeMatch(storeMatch),
    .rdMiss(rdToMem), .drReady(drReady), .strobes(strobes),
    .headPtr(headPtr), .tailPtr(tailPtr), .full(full),
    .stStall(stStall), .drValid(drValid)
  );

  merge_wbuf_dp #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .WORDS(WORDS), .DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .headPtr(headPtr), .tailPtr(tailPtr),
    .stAddr(stAddr), .stData(stData), .rdAddr(rdAddr), .storeMatch(storeMatch),
    .rawHit(rawHit), .rdData(rdData), .drAddr(drAddr), .drData(drData), .drMask(drMask)
  );
endmodule

// File: rtl/merge_wbuf_chk.sv
module merge_wbuf_chk #(
  parameter int TAG_W  = 14,
  parameter int DATA_W = 32,
  parameter int WORDS  = 4
) (
  input logic                    clk,
  input logic                    rstN,
  input logic                    stStall,
  input logic                    full,
  input logic                    rdToMem,
  input logic                    drValid,
  input logic                    drReady,
  input logic [TAG_W-1:0]        drAddr,
  input logic [WORDS*DATA_W-1:0] drData,
  input logic [WORDS-1:0]        drMask
);
  AST_DRAIN_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    drValid && !drReady |=> drValid && $stable(drAddr) && $stable(drData) && $stable(drMask)); // R9
  AST_MASK_SET: assert property (@(posedge clk) disable iff (!rstN)
    drValid |-> drMask != '0); // R2
  AST_STALL_FULL: assert property (@(posedge clk) disable iff (!rstN)
    stStall |-> full); // R5
  AST_READ_FIRST: assert property (@(posedge clk) disable iff (!rstN)
    rdToMem && !drValid |=> !drValid); // R8
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    full && !(drValid && drReady) |=> full); // R10
endmodule

bind merge_wbuf merge_wbuf_chk #(.TAG_W(TAG_W), .DATA_W(DATA_W), .WORDS(WORDS)) u_chk (
  .clk(clk), .rstN(rstN), .stStall(stStall), .full(full), .rdToMem(rdToMem),
  .drValid(drValid), .drReady(drReady), .drAddr(drAddr), .drData(drData), .drMask(drMask)
);

// File: tb/merge_wbuf_tb.sv
module merge_wbuf_tb;
  localparam int AW = 16, DW = 32, NW = 4, TW = 14;
  localparam logic [AW-1:0] HOLD_ADDR = 16'hFFF0;

  typedef struct {
    logic [TW-1:0]    addr;
    logic [NW-1:0]    mask;
    logic [NW*DW-1:0] data;
    string            req;
  } drainItem_t;

  logic clk = 1'b0, rstN = 1'b0;
  logic stValid = 1'b0, rdValid = 1'b0, drReady = 1'b0;
  logic [AW-1:0] stAddr = '0, rdAddr = '0;
  logic [DW-1:0] stData = '0;
  logic stStall, full, rdHit, rdToMem, drValid;
  logic [DW-1:0] rdData;
  logic [TW-1:0] drAddr;
  logic [NW*DW-1:0] drData;
  logic [NW-1:0] drMask;

  int checks = 0, fails = 0;
  drainItem_t expQ[$];

  always #10 clk = ~clk;

  merge_wbuf u_dut (
    .clk(clk), .rstN(rstN), .stValid(stValid), .stAddr(stAddr), .stData(stData),
    .stStall(stStall), .full(full), .rdValid(rdValid), .rdAddr(rdAddr), .rdHit(rdHit),
    .rdData(rdData), .rdToMem(rdToMem), .drValid(drValid), .drReady(drReady),
    .drAddr(drAddr), .drData(drData), .drMask(drMask)
  );

  task automatic chk(input string req, input logic [NW*DW-1:0] act, input logic [NW*DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic drainItem_t mk(input logic [TW-1:0] a, input logic [NW-1:0] m,
                                    input logic [DW-1:0] w0, input logic [DW-1:0] w1,
                                    input logic [DW-1:0] w2, input logic [DW-1:0] w3,
                                    input string req);
    drainItem_t it;
    it.addr = a; it.mask = m; it.data = {w3, w2, w1, w0}; it.req = req;
    return it;
  endfunction

  task automatic doStore(input logic [AW-1:0] a, input logic [DW-1:0] d, output int stalls);
    @(negedge clk);
    stValid = 1'b1; stAddr = a; stData = d; stalls = 0;
    #1;
    while (stStall) begin
      stalls++;
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    stValid = 1'b0;
  endtask

  task automatic waitDrained();
    for (int n = 0; n < 300 && expQ.size() != 0; n++) @(negedge clk);
    chk("R4", expQ.size(), 0);
    repeat (3) @(negedge clk);
    #1 chk("R10", drValid, 0);
  endtask

  // Monitor: compares each accepted drain with the oldest expected item.
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rstN && drValid && drReady) begin
        if (expQ.size() == 0) begin
          chk("R4", 1, 0);
        end else begin
          drainItem_t e;
          logic [NW*DW-1:0] got;
          e = expQ.pop_front();
          got = '0;
          for (int w = 0; w < NW; w++)
            if (e.mask[w]) got[w*DW +: DW] = drData[w*DW +: DW];
          chk(e.req, drAddr, e.addr);
          chk(e.req, drMask, e.mask);
          chk(e.req, got, e.data);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int st;
    repeat (3) @(negedge clk);
    #1;
    chk("R1", drValid, 0);
    chk("R1", full, 0);
    chk("R1", stStall, 0);
    rstN = 1'b1;

    // Pattern 1: interleaved blocks with a rewrite, drains held off by a read miss.
    @(negedge clk);
    rdValid = 1'b1; rdAddr = HOLD_ADDR;
    doStore(16'h0041, 32'hA1A1_0001, st);
    doStore(16'h0080, 32'hB2B2_0002, st);
    doStore(16'h0043, 32'hC3C3_0003, st);
    doStore(16'h0041, 32'hD4D4_0004, st);
    chk("R3", st, 0);
    expQ.push_back(mk(14'h10, 4'b1010, 0, 32'hD4D4_0004, 0, 32'hC3C3_0003, "R3"));
    expQ.push_back(mk(14'h20, 4'b0001, 32'hB2B2_0002, 0, 0, 0, "R2"));
    @(negedge clk);
    rdAddr = 16'h0043; #1;
    chk("R7", rdHit, 1);
    chk("R7", rdData, 32'hC3C3_0003);
    rdAddr = 16'h0041; #1;
    chk("R7", rdData, 32'hD4D4_0004);
    rdAddr = 16'h0042; #1;
    chk("R8", rdToMem, 1);
    chk("R8", rdHit, 0);
    rdAddr = HOLD_ADDR;
    repeat (3) @(negedge clk);
    #1 chk("R8", drValid, 0);
    rdValid = 1'b0; drReady = 1'b1;
    waitDrained();

    // Pattern 2: fill every slot, merge while full, then a stalled new block.
    @(negedge clk);
    drReady = 1'b0; rdValid = 1'b1; rdAddr = HOLD_ADDR;
    doStore(16'h0004, 32'h1111_0001, st);
    doStore(16'h0008, 32'h2222_0002, st);
    doStore(16'h000C, 32'h3333_0003, st);
    doStore(16'h0010, 32'h4444_0004, st);
    @(negedge clk); #1;
    chk("R5", full, 1);
    doStore(16'h000A, 32'h2222_00AA, st);
    chk("R5", st, 0);
    expQ.push_back(mk(14'h1, 4'b0001, 32'h1111_0001, 0, 0, 0, "R4"));
    expQ.push_back(mk(14'h2, 4'b0101, 32'h2222_0002, 0, 32'h2222_00AA, 0, "R4"));
    expQ.push_back(mk(14'h3, 4'b0001, 32'h3333_0003, 0, 0, 0, "R4"));
    expQ.push_back(mk(14'h4, 4'b0001, 32'h4444_0004, 0, 0, 0, "R4"));
    expQ.push_back(mk(14'h5, 4'b0001, 32'h5555_0005, 0, 0, 0, "R10"));
    @(negedge clk);
    stValid = 1'b1; stAddr = 16'h0014; stData = 32'h5555_0005;
    #1 chk("R5", stStall, 1);
    rdValid = 1'b0; drReady = 1'b1;
    st = 0;
    while (stStall && st < 100) begin
      st++;
      @(negedge clk); #1;
    end
    @(posedge clk); #1;
    stValid = 1'b0;
    chk("R10", (st >= 1), 1);
    waitDrained();

    // Pattern 3: store into the block that is on the drain port.
    @(negedge clk);
    drReady = 1'b0;
    doStore(16'h00C0, 32'hEEEE_0001, st);
    for (int n = 0; n < 20 && !drValid; n++) begin
      @(negedge clk); #1;
    end
    chk("R6", drValid, 1);
    doStore(16'h00C1, 32'hFFFF_0002, st);
    repeat (2) @(negedge clk);
    #1;
    chk("R9", drAddr, 14'h30);
    chk("R6", drMask, 4'b0001);
    chk("R9", drData[DW-1:0], 32'hEEEE_0001);
    expQ.push_back(mk(14'h30, 4'b0001, 32'hEEEE_0001, 0, 0, 0, "R6"));
    expQ.push_back(mk(14'h30, 4'b0010, 0, 32'hFFFF_0002, 0, 0, "R6"));
    drReady = 1'b1;
    waitDrained();

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule